// File: doc/BRIEF.md
# Descriptor Sequence Number Validator

This block checks every DMA descriptor that a multi-context DMA engine fetches before the engine is allowed to use it. Software stamps each descriptor it places in a ring with a sequence number, and each new descriptor gets the next number. For every context the block keeps one expected number for the transmit ring and one for the receive ring. When a descriptor arrives with its context, ring and sequence number, the block compares the number with the expected one. On a match the descriptor is accepted and the expectation moves forward by one, wrapping at the top of the sequence space. On a mismatch the descriptor is refused, the ring freezes, and a protection fault is reported to the privileged management side.

A ring can be handed a descriptor that is left over from an earlier trip around it. Such a leftover carries a number exactly one ring depth behind the expected one. The sequence space is at least twice the ring depth, so that leftover number can never equal the expected value. The fault record marks this case separately from a plain gap.

The management side can do four things:
- Activate a context.
- Revoke a context.
- Reload the expectation of one ring, which also thaws a frozen ring.
- Acknowledge the sticky fault record.

Top module: `desc_seq_check`

## Requirements
- R1: After reset no result is reported, every context is inactive, no ring is frozen and the fault record is empty (`flt_vld` low).
- R2: A descriptor presented with `dsc_vld` produces `res_vld` one cycle later. `res_ok` is high only if the context is active, the ring is not frozen and `dsc_seq` equals that ring's expected value.
- R3: Each accepted descriptor advances its own ring's expected value by one, modulo 2^SEQ_W. The rings of all contexts advance independently of each other.
- R4: A live ring that sees a mismatching number refuses the descriptor and raises `flt_pulse` for one cycle in the result cycle. The ring freezes (`frz_vec` bit 2*ctx+ring, with ring 0 = transmit and ring 1 = receive) and its expected value is kept unchanged.
- R5: A frozen ring refuses every descriptor, including one carrying the correct number. It raises no further `flt_pulse` until it is reloaded, initialized or revoked.
- R6: The fault record captures context, ring, expected value and received value of a fault when it is empty. It then stays unchanged while `flt_vld` is high, even through later faults, until an acknowledge clears it.
- R7: `flt_stale` in the record is high exactly when the received number equals the expected number minus RING_SLOTS, modulo 2^SEQ_W.
- R8: Management operations are coded as follows: `mgmt_op` 0 revokes, 1 initializes, 2 reloads, 3 acknowledges. Initialize and revoke clear both expected values of `mgmt_ctx` to 0 and thaw both of its rings. Initialize sets the context's `act_vec` bit and revoke clears it. Descriptors for an inactive context are refused without a fault.
- R9: A reload sets the expected value of ring `mgmt_ring` of `mgmt_ctx` to `mgmt_seq` and thaws that ring. It leaves the other ring untouched.
- R10: When a management write and a descriptor fall in the same cycle, the descriptor is judged against the state from before the write, and the write decides the new contents of every register it targets. A fault that meets an acknowledge is captured in the record.
- R11: The parameters satisfy 2^SEQ_W >= 2*RING_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsc_vld | input | 1 | Descriptor present this cycle |
| dsc_ctx | input | CTX_W | Context of the descriptor |
| dsc_ring | input | 1 | Ring of the descriptor, 0 transmit, 1 receive |
| dsc_seq | input | SEQ_W | Sequence number carried by the descriptor |
| mgmt_we | input | 1 | Management operation strobe |
| mgmt_op | input | 2 | 0 revoke, 1 initialize, 2 reload, 3 acknowledge |
| mgmt_ctx | input | CTX_W | Context targeted by the operation |
| mgmt_ring | input | 1 | Ring targeted by a reload |
| mgmt_seq | input | SEQ_W | Expected value loaded by a reload |
| res_vld | output | 1 | Result of the previous cycle's descriptor |
| res_ok | output | 1 | Descriptor accepted |
| flt_pulse | output | 1 | New protection fault this result |
| flt_vld | output | 1 | Sticky fault record valid |
| flt_ctx | output | CTX_W | Context of the recorded fault |
| flt_ring | output | 1 | Ring of the recorded fault |
| flt_exp | output | SEQ_W | Expected number at the recorded fault |
| flt_got | output | SEQ_W | Received number at the recorded fault |
| flt_stale | output | 1 | Recorded number is one ring depth behind |
| act_vec | output | NUM_CTX | Active flag per context |
| frz_vec | output | 2*NUM_CTX | Frozen flag per ring |

## Verification
Two functions can fall in the same cycle: the descriptor check and a management write that touches the same ring or the fault record. The bench provokes this by driving a reload together with a descriptor for the same ring, and separately an acknowledge together with a mismatching descriptor. It judges the first case by checking that the result follows the old expected value while the following descriptor follows the reloaded one. It judges the second by checking that the record holds the new fault. Around this, an exhaustive sweep of every expected value against every received value on one ring checks acceptance, faulting and the stale marking arithmetically.

// File: rtl/desc_seq_check.sv
module desc_seq_check #(
  parameter int NUM_CTX    = 4,
  parameter int RING_SLOTS = 8,
  parameter int SEQ_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dsc_vld,
  input  logic [CTX_W-1:0]         dsc_ctx,
  input  logic                     dsc_ring,
  input  logic [SEQ_W-1:0]         dsc_seq,
  input  logic                     mgmt_we,
  input  logic [1:0]               mgmt_op,
  input  logic [CTX_W-1:0]         mgmt_ctx,
  input  logic                     mgmt_ring,
  input  logic [SEQ_W-1:0]         mgmt_seq,
  output logic                     res_vld,
  output logic                     res_ok,
  output logic                     flt_pulse,
  output logic                     flt_vld,
  output logic [CTX_W-1:0]         flt_ctx,
  output logic                     flt_ring,
  output logic [SEQ_W-1:0]         flt_exp,
  output logic [SEQ_W-1:0]         flt_got,
  output logic                     flt_stale,
  output logic [NUM_CTX-1:0]       act_vec,
  output logic [2*NUM_CTX-1:0]     frz_vec
);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int NRING = 2 * NUM_CTX;
  localparam int RID_W = CTX_W + 1;
  localparam logic [SEQ_W-1:0] SLOTS = SEQ_W'(RING_SLOTS);
  localparam logic [1:0] OP_REVOKE = 2'd0;
  localparam logic [1:0] OP_INIT   = 2'd1;
  localparam logic [1:0] OP_RELOAD = 2'd2;
  localparam logic [1:0] OP_ACK    = 2'd3;

  logic [NRING-1:0][SEQ_W-1:0] exp_q;
  logic [NRING-1:0]            frz_q;
  logic [NUM_CTX-1:0]          act_q;

  wire [RID_W-1:0] d_rid   = {dsc_ctx, dsc_ring};
  wire [RID_W-1:0] m_rid   = {mgmt_ctx, mgmt_ring};
  wire [SEQ_W-1:0] d_exp   = exp_q[d_rid];
  wire             d_live  = dsc_vld & act_q[dsc_ctx] & ~frz_q[d_rid];
  wire             d_ok    = d_live & (dsc_seq == d_exp);
  wire             d_bad   = d_live & (dsc_seq != d_exp);
  wire             d_stale = (dsc_seq == d_exp - SLOTS);
  wire             m_clr   = mgmt_we & ((mgmt_op == OP_INIT) | (mgmt_op == OP_REVOKE));
  wire             m_rld   = mgmt_we & (mgmt_op == OP_RELOAD);
  wire             m_ack   = mgmt_we & (mgmt_op == OP_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      frz_q <= '0;
      act_q <= '0;
    end else begin
      for (int i = 0; i < NRING; i++) begin
        if (m_clr && mgmt_ctx == CTX_W'(i / 2)) begin
          exp_q[i] <= '0;
          frz_q[i] <= 1'b0;
        end else if (m_rld && m_rid == RID_W'(i)) begin
          exp_q[i] <= mgmt_seq;
          frz_q[i] <= 1'b0;
        end else if (d_rid == RID_W'(i)) begin
          if (d_ok)  exp_q[i] <= exp_q[i] + 1'b1;
          if (d_bad) frz_q[i] <= 1'b1;
        end
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (mgmt_we && mgmt_ctx == CTX_W'(c)) begin
          if (mgmt_op == OP_INIT)        act_q[c] <= 1'b1;
          else if (mgmt_op == OP_REVOKE) act_q[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_ok    <= 1'b0;
      flt_pulse <= 1'b0;
      flt_vld   <= 1'b0;
      flt_ctx   <= '0;
      flt_ring  <= 1'b0;
      flt_exp   <= '0;
      flt_got   <= '0;
      flt_stale <= 1'b0;
    end else begin
      res_vld   <= dsc_vld;
      res_ok    <= d_ok;
      flt_pulse <= d_bad;
      if (d_bad && (!flt_vld || m_ack)) begin
        flt_vld   <= 1'b1;
        flt_ctx   <= dsc_ctx;
        flt_ring  <= dsc_ring;
        flt_exp   <= d_exp;
        flt_got   <= dsc_seq;
        flt_stale <= d_stale;
      end else if (m_ack) begin
        flt_vld   <= 1'b0;
      end
    end
  end

  assign act_vec = act_q;
  assign frz_vec = frz_q;
endmodule

// File: rtl/desc_seq_check_props.sv
module desc_seq_check_props #(
  parameter int NUM_CTX    = 4,
  parameter int RING_SLOTS = 8,
  parameter int SEQ_W      = 4,
  parameter int CTX_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dsc_vld,
  input logic [CTX_W-1:0]     dsc_ctx,
  input logic                 dsc_ring,
  input logic [SEQ_W-1:0]     dsc_seq,
  input logic                 mgmt_we,
  input logic [1:0]           mgmt_op,
  input logic                 res_vld,
  input logic                 res_ok,
  input logic                 flt_pulse,
  input logic                 flt_vld,
  input logic [CTX_W-1:0]     flt_ctx,
  input logic                 flt_ring,
  input logic [SEQ_W-1:0]     flt_exp,
  input logic [SEQ_W-1:0]     flt_got,
  input logic [NUM_CTX-1:0]   act_vec,
  input logic [2*NUM_CTX-1:0] frz_vec
);
  initial a_r11_no_alias: assert ((2 ** SEQ_W) >= 2 * RING_SLOTS);

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_vld |=> res_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dsc_vld |=> !res_vld);
  a_r4_fault_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pulse |-> (res_vld && !res_ok && flt_vld));
  a_r5_frozen_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_vld && frz_vec[{dsc_ctx, dsc_ring}]) |=> (!res_ok && !flt_pulse));
  a_r8_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_vld && !act_vec[dsc_ctx]) |=> (!res_ok && !flt_pulse));
  a_r6_record_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && !(mgmt_we && mgmt_op == 2'd3)) |=>
      (flt_vld && $stable(flt_ctx) && $stable(flt_ring) && $stable(flt_exp) && $stable(flt_got)));
endmodule

bind desc_seq_check desc_seq_check_props #(
  .NUM_CTX(NUM_CTX), .RING_SLOTS(RING_SLOTS), .SEQ_W(SEQ_W), .CTX_W(CTX_W)
) u_props (.*);

// File: tb/tb_desc_seq_check.sv
module tb_desc_seq_check;
  localparam int NC = 4, SL = 8, SW = 4, MOD = 16;

  logic clk = 0, rst_n = 0;
  logic dsc_vld = 0, dsc_ring = 0, mgmt_we = 0, mgmt_ring = 0;
  logic [1:0] dsc_ctx = 0, mgmt_ctx = 0, mgmt_op = 0;
  logic [SW-1:0] dsc_seq = 0, mgmt_seq = 0;
  logic res_vld, res_ok, flt_pulse, flt_vld, flt_ring, flt_stale;
  logic [1:0] flt_ctx;
  logic [SW-1:0] flt_exp, flt_got;
  logic [NC-1:0] act_vec;
  logic [2*NC-1:0] frz_vec;

  desc_seq_check #(.NUM_CTX(NC), .RING_SLOTS(SL), .SEQ_W(SW)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_exp [2*NC];
  bit m_frz [2*NC];
  bit m_act [NC];
  bit m_fv, m_fr, m_fs;
  int m_fc, m_fe, m_fg;

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_rec(string tag);
    check({tag, " flt_vld"}, flt_vld, m_fv);
    if (m_fv) begin
      check({tag, " flt_ctx"}, flt_ctx, m_fc);
      check({tag, " flt_ring"}, flt_ring, m_fr);
      check({tag, " flt_exp"}, flt_exp, m_fe);
      check({tag, " flt_got"}, flt_got, m_fg);
      check({tag, " flt_stale"}, flt_stale, m_fs);
    end
  endtask

  function automatic void model_mgmt(int op, int c, int r, int s);
    if (op == 0 || op == 1) begin
      m_act[c] = (op == 1);
      for (int k = 0; k < 2; k++) begin m_exp[2*c+k] = 0; m_frz[2*c+k] = 0; end
    end else if (op == 2) begin
      m_exp[2*c+r] = s; m_frz[2*c+r] = 0;
    end
  endfunction

  task automatic drive_mgmt(int op, int c, int r, int s);
    mgmt_we = 1; mgmt_op = 2'(op); mgmt_ctx = 2'(c); mgmt_ring = r[0]; mgmt_seq = SW'(s);
  endtask

  task automatic drive_desc(int c, int r, int s);
    dsc_vld = 1; dsc_ctx = 2'(c); dsc_ring = r[0]; dsc_seq = SW'(s);
  endtask

  task automatic mgmt(int op, int c, int r, int s);
    @(negedge clk); drive_mgmt(op, c, r, s);
    @(negedge clk); mgmt_we = 0;
    model_mgmt(op, c, r, s);
    if (op == 3) m_fv = 0;
  endtask

  // optional simultaneous management op (op < 0 means none)
  task automatic desc_m(string tag, int c, int r, int s, int op, int mc, int mr, int ms);
    int i = 2*c + r;
    bit live = m_act[c] && !m_frz[i];
    bit ok = live && (s == m_exp[i]);
    bit bad = live && !ok;
    int e = m_exp[i];
    @(negedge clk);
    drive_desc(c, r, s);
    if (op >= 0) drive_mgmt(op, mc, mr, ms);
    @(negedge clk);
    dsc_vld = 0; mgmt_we = 0;
    check({tag, " res_vld"}, res_vld, 1);
    check({tag, " res_ok"}, res_ok, ok);
    check({tag, " flt_pulse"}, flt_pulse, bad);
    if (ok) m_exp[i] = (e + 1) % MOD;
    if (bad) m_frz[i] = 1;
    if (op >= 0) model_mgmt(op, mc, mr, ms);
    if (bad && (!m_fv || op == 3)) begin
      m_fv = 1; m_fc = c; m_fr = r; m_fe = e; m_fg = s;
      m_fs = (s == (e - SL + MOD) % MOD);
    end else if (op == 3) m_fv = 0;
  endtask

  task automatic desc(string tag, int c, int r, int s);
    desc_m(tag, c, r, s, -1, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2*NC; i++) begin m_exp[i] = 0; m_frz[i] = 0; end
    for (int c = 0; c < NC; c++) m_act[c] = 0;
    m_fv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 res_vld", res_vld, 0);
    check("R1 act_vec", act_vec, 0);
    check("R1 frz_vec", frz_vec, 0);
    check("R1 flt_vld", flt_vld, 0);

    // R8 inactive context refused silently
    desc("R8 inactive", 1, 0, 0);
    check("R8 frz after inactive", frz_vec, 0);
    for (int c = 0; c < NC; c++) mgmt(1, c, 0, 0);
    check("R8 act after init", act_vec, 4'hF);

    // R3 continuity with wrap, rings interleaved
    for (int k = 0; k < 20; k++)
      for (int i = 0; i < 2*NC; i++)
        desc("R3 sequence", i / 2, i % 2, m_exp[i]);

    // R4 gap on ctx 2 rx
    desc("R4 gap", 2, 1, (m_exp[5] + 1) % MOD);
    check("R4 frz_vec", frz_vec, 8'h20);
    chk_rec("R6 first fault");
    // R5 frozen refuses correct number
    desc("R5 frozen correct", 2, 1, m_exp[5]);
    desc("R5 frozen wrong", 2, 1, (m_exp[5] + 3) % MOD);
    // R3 other ring of same context unaffected
    desc("R3 sibling ring", 2, 0, m_exp[4]);
    // R6 second fault does not overwrite
    desc("R6 second fault", 0, 0, (m_exp[0] + 2) % MOD);
    chk_rec("R6 sticky");
    // R9 reload thaws only named ring
    mgmt(2, 2, 1, 9);
    check("R9 frz after reload", frz_vec, 8'h01);
    desc("R9 reloaded value", 2, 1, 9);
    mgmt(3, 0, 0, 0);
    chk_rec("R6 ack clears");

    // R7 exhaustive expected x received sweep on ctx 3 tx
    for (int e = 0; e < MOD; e++)
      for (int s = 0; s < MOD; s++) begin
        mgmt(2, 3, 0, e);
        mgmt(3, 0, 0, 0);
        desc("R7 sweep", 3, 0, s);
        chk_rec("R7 sweep record");
      end

    // R8 revoke: refused silently, re-init restarts at 0
    mgmt(0, 1, 0, 0);
    check("R8 act after revoke", act_vec, 4'b1101);
    desc("R8 revoked", 1, 0, 0);
    mgmt(1, 1, 0, 0);
    desc("R8 reinit start", 1, 1, 0);

    // R10 reload and descriptor on same ring in same cycle
    mgmt(3, 0, 0, 0);
    desc_m("R10 old state judged", 1, 0, m_exp[2], 2, 1, 0, 12);
    desc("R10 reload wins", 1, 0, 12);
    // R10 fault meets acknowledge while record full
    desc("R10 setup fault", 0, 1, (m_exp[1] + 5) % MOD);
    desc_m("R10 fault with ack", 1, 1, (m_exp[3] + 7) % MOD, 3, 0, 0, 0);
    chk_rec("R10 record after ack");
    // R10 init same cycle as mismatch: thawed by init
    desc_m("R10 init vs fault", 2, 0, (m_exp[4] + 1) % MOD, 1, 2, 0, 0);
    check("R10 frz after init", frz_vec[4], 0);
    desc("R10 init exp zero", 2, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule